// File: doc/BRIEF.md
# SPI Master Controller Register Front End

This block is the bus-facing half of a four-channel SPI master controller. It decodes word-aligned 32-bit reads and writes from a simple request/response bus, keeps the configuration words the serial engine and interrupt logic consume, and owns the two 64-word data queues: software fills the transmit queue and empties the receive queue, while the serial engine drains and fills them through a separate port on the other side.

The front end also decides when a transfer begins. Depending on the control word, a burst is launched automatically after each accepted transmit write, or by a rising edge of the exchange bit. It drives four active-low chip selects from the selected channel when that channel is configured as a master. Writing the control word with its enable bit clear acts as a full soft reset of every register, both queues and the engine's burst state. Status flag generation and the serial shifter are outside this block; the status word is read from an input.

Top module: `spi_regfront`

## Requirements
- R1: After reset every stored register reads 0, both queues are empty, all chip selects are high and no start or clear pulse is driven.
- R2: The register index is the byte address shifted right by 2. Map: 0x00 receive data, 0x04 transmit data, 0x08 control, 0x0C configuration, 0x10 interrupt enable, 0x14 DMA, 0x18 status, 0x1C period, 0x20 test, 0x40 message data. An access whose address is not a multiple of 4, or which hits no listed offset, writes nothing and reads 0. Read data appears with `rsp_valid` one cycle after the request.
- R3: Control, configuration, interrupt enable, DMA, period and test read back the last value written; the status offset reads `stat_i` and ignores writes.
- R4: A receive data read returns 0 without popping when enable (control bit 0) is clear, returns 0xDEADBEEF when the receive queue is empty, and otherwise pops and returns the oldest word.
- R5: Reads of transmit data and message data return 0; writes to receive data change nothing.
- R6: A write to transmit data or message data pushes the word only when enabled and the transmit queue holds fewer than 64 words; otherwise the word is dropped.
- R7: The selected channel is control bits 19:18; it is a master when control bit 4+channel is set. A control write with enable set and a master channel drives that chip select low and the other three high; other control writes leave the chip selects unchanged.
- R8: An accepted transmit write while the channel is a master and start-on-write (control bit 3) is set yields a one-cycle `seq_start_o` pulse in the following cycle.
- R9: A control write with enable set and a master channel pulses `seq_start_o` when bit 3 changes 0 to 1 with the transmit queue non-empty, or when exchange (bit 2) changes 0 to 1 while the new bit 3 is 0; no other control write starts a burst.
- R10: A control write with bit 0 clear zeroes all stored registers, empties both queues, raises all chip selects and pulses `eng_clear_o` for one cycle.
- R11: Engine pushes into a full receive queue are dropped; the transmit queue presents its oldest word on `txq_data_o` until the engine pops it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| ctl_o | output | 32 | Control word |
| cfg_o | output | 32 | Configuration word |
| int_en_o | output | 32 | Interrupt enable word |
| dma_o | output | 32 | DMA word |
| period_o | output | 32 | Period word |
| test_o | output | 32 | Test word |
| stat_i | input | 32 | Status word from flag logic |
| cs_n_o | output | 4 | Active-low chip selects |
| seq_start_o | output | 1 | Burst start pulse |
| eng_clear_o | output | 1 | Soft-reset pulse to the engine |
| txq_pop_i | input | 1 | Engine pops the transmit queue |
| txq_data_o | output | 32 | Oldest transmit word |
| txq_empty_o | output | 1 | Transmit queue empty |
| rxq_push_i | input | 1 | Engine pushes a received word |
| rxq_data_i | input | 32 | Received word |

## Verification
The hardest case to reach is the start triggered by start-on-write turning on while the transmit queue already holds data, because with that mode off in master mode a transmit write must not start anything, so the bench primes the queue first and only then flips the mode bit, then repeats the same control value to show no second start. The queue-full drop boundaries need exactly 64 accepted words followed by one more, which the bench reaches by filling through the bus and draining through the engine port, checking the last surviving word and the empty flag afterwards.

// File: rtl/spi_rf_pkg.sv
package spi_rf_pkg;
  // control word field positions (decoded by the engine as well)
  localparam int unsigned CTL_EN       = 0;
  localparam int unsigned CTL_XCH      = 2;
  localparam int unsigned CTL_AUTO     = 3;
  localparam int unsigned CTL_MODE_LSB = 4;
  localparam int unsigned CTL_SEL_LSB  = 18;

  localparam logic [31:0] RX_EMPTY_WORD = 32'hDEAD_BEEF;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_RXD, SEL_TXD, SEL_CTL, SEL_CFG, SEL_INT,
    SEL_DMA, SEL_STAT, SEL_PER, SEL_TST, SEL_MSG
  } reg_sel_e;
endpackage

// File: rtl/spi_rf_fifo.sv
module spi_rf_fifo #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int unsigned PW = $clog2(DEPTH);
  localparam int unsigned CW = PW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          push_ok, pop_ok;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign push_ok = push && !full && !flush;
  assign pop_ok  = pop && !empty && !flush;
  assign rdata   = mem[rd_q];

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (flush) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      if (push_ok) wr_d = bump(wr_q);
      if (pop_ok)  rd_d = bump(rd_q);
      if (push_ok && !pop_ok) cnt_d = cnt_q + 1'b1;
      else if (pop_ok && !push_ok) cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_q] <= wdata;
  end

  // R6 / R11: occupancy never exceeds the depth
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  // R11: a push into a full queue without a pop leaves it full
  assert_full_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !flush) |=> full);
endmodule

// File: rtl/spi_rf_launch.sv
module spi_rf_launch #(
  parameter int unsigned NCH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clear,
  input  logic                       ctl_wr,
  input  logic [NCH-1:0]             mode_old,
  input  logic [$clog2(NCH)-1:0]     sel_old,
  input  logic                       auto_old,
  input  logic                       xch_old,
  input  logic [NCH-1:0]             mode_new,
  input  logic [$clog2(NCH)-1:0]     sel_new,
  input  logic                       auto_new,
  input  logic                       xch_new,
  input  logic                       tx_acc,
  input  logic                       tx_nonempty,
  output logic [NCH-1:0]             cs_n,
  output logic                       start
);
  localparam int unsigned SW = $clog2(NCH);

  logic [NCH-1:0] cs_q, cs_d;
  logic           start_q, start_d;
  logic           master_old, master_new, ctl_go;

  assign master_old = mode_old[sel_old];
  assign master_new = mode_new[sel_new];
  assign ctl_go = (auto_new && !auto_old && tx_nonempty) ||
                  (xch_new && !xch_old && !auto_new);

  always_comb begin
    cs_d    = cs_q;
    start_d = 1'b0;
    if (clear) begin
      cs_d = '1;
    end else begin
      if (ctl_wr && master_new) begin
        for (int i = 0; i < NCH; i++) cs_d[i] = (SW'(i) != sel_new);
        start_d = ctl_go;
      end
      if (tx_acc && master_old && auto_old) start_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q    <= '1;
      start_q <= 1'b0;
    end else begin
      cs_q    <= cs_d;
      start_q <= start_d;
    end
  end

  assign cs_n  = cs_q;
  assign start = start_q;

  // R7: at most one chip select is active
  assert_cs_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));
  // R8 / R9: a start pulse always follows a transmit or control write
  assert_start_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> $past(tx_acc || ctl_wr));
  // R10: soft reset raises every chip select
  assert_clear_cs_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cs_n == '1) && !start);
endmodule

// File: rtl/spi_regfront.sv
module spi_regfront
  import spi_rf_pkg::*;
#(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned FIFO_DEPTH = 64,
  parameter int unsigned NCH        = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic [31:0]       ctl_o,
  output logic [31:0]       cfg_o,
  output logic [31:0]       int_en_o,
  output logic [31:0]       dma_o,
  output logic [31:0]       period_o,
  output logic [31:0]       test_o,
  input  logic [31:0]       stat_i,
  output logic [NCH-1:0]    cs_n_o,
  output logic              seq_start_o,
  output logic              eng_clear_o,
  input  logic              txq_pop_i,
  output logic [31:0]       txq_data_o,
  output logic              txq_empty_o,
  input  logic              rxq_push_i,
  input  logic [31:0]       rxq_data_i
);
  localparam int unsigned IDX_W = ADDR_W - 2;
  localparam int unsigned SW    = $clog2(NCH);

  logic [31:0] ctl_q, ctl_d, cfg_q, cfg_d, int_q, int_d;
  logic [31:0] dma_q, dma_d, per_q, per_d, tst_q, tst_d;
  logic [31:0] rdata_q, rdata_d, rd_mux, rx_word;
  logic        rvalid_q, clr_q;
  reg_sel_e    sel;
  logic [IDX_W-1:0] idx;
  logic wr, rd, enabled, ctl_wr_any, soft_rst, ctl_wr_on;
  logic tx_acc, tx_full, rx_pop, rx_empty, rx_full;

  assign idx = req_addr[ADDR_W-1:2];
  assign wr  = req_valid && req_write;
  assign rd  = req_valid && !req_write;
  assign enabled = ctl_q[CTL_EN];

  always_comb begin
    sel = SEL_NONE;
    if (req_addr[1:0] == 2'b00) begin
      case (idx)
        IDX_W'(0):  sel = SEL_RXD;
        IDX_W'(1):  sel = SEL_TXD;
        IDX_W'(2):  sel = SEL_CTL;
        IDX_W'(3):  sel = SEL_CFG;
        IDX_W'(4):  sel = SEL_INT;
        IDX_W'(5):  sel = SEL_DMA;
        IDX_W'(6):  sel = SEL_STAT;
        IDX_W'(7):  sel = SEL_PER;
        IDX_W'(8):  sel = SEL_TST;
        IDX_W'(16): sel = SEL_MSG;
        default:    sel = SEL_NONE;
      endcase
    end
  end

  assign ctl_wr_any = wr && (sel == SEL_CTL);
  assign soft_rst   = ctl_wr_any && !req_wdata[CTL_EN];
  assign ctl_wr_on  = ctl_wr_any && req_wdata[CTL_EN];
  assign tx_acc     = wr && ((sel == SEL_TXD) || (sel == SEL_MSG)) && enabled && !tx_full;
  assign rx_pop     = rd && (sel == SEL_RXD) && enabled && !rx_empty;

  // read data selection
  always_comb begin
    case (sel)
      SEL_RXD:  rd_mux = !enabled ? 32'h0 : (rx_empty ? RX_EMPTY_WORD : rx_word);
      SEL_CTL:  rd_mux = ctl_q;
      SEL_CFG:  rd_mux = cfg_q;
      SEL_INT:  rd_mux = int_q;
      SEL_DMA:  rd_mux = dma_q;
      SEL_STAT: rd_mux = stat_i;
      SEL_PER:  rd_mux = per_q;
      SEL_TST:  rd_mux = tst_q;
      default:  rd_mux = 32'h0;
    endcase
  end

  // register next state
  always_comb begin
    ctl_d = ctl_q; cfg_d = cfg_q; int_d = int_q;
    dma_d = dma_q; per_d = per_q; tst_d = tst_q;
    rdata_d = rd ? rd_mux : 32'h0;
    if (soft_rst) begin
      ctl_d = '0; cfg_d = '0; int_d = '0;
      dma_d = '0; per_d = '0; tst_d = '0;
    end else if (wr) begin
      case (sel)
        SEL_CTL: ctl_d = req_wdata;
        SEL_CFG: cfg_d = req_wdata;
        SEL_INT: int_d = req_wdata;
        SEL_DMA: dma_d = req_wdata;
        SEL_PER: per_d = req_wdata;
        SEL_TST: tst_d = req_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0; cfg_q <= '0; int_q <= '0;
      dma_q <= '0; per_q <= '0; tst_q <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
      clr_q    <= 1'b0;
    end else begin
      ctl_q <= ctl_d; cfg_q <= cfg_d; int_q <= int_d;
      dma_q <= dma_d; per_q <= per_d; tst_q <= tst_d;
      rdata_q  <= rdata_d;
      rvalid_q <= rd;
      clr_q    <= soft_rst;
    end
  end

  spi_rf_fifo #(.W(32), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(soft_rst),
    .push(tx_acc), .wdata(req_wdata),
    .pop(txq_pop_i), .rdata(txq_data_o),
    .empty(txq_empty_o), .full(tx_full));

  spi_rf_fifo #(.W(32), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(soft_rst),
    .push(rxq_push_i), .wdata(rxq_data_i),
    .pop(rx_pop), .rdata(rx_word),
    .empty(rx_empty), .full(rx_full));

  spi_rf_launch #(.NCH(NCH)) u_launch (
    .clk(clk), .rst_n(rst_n), .clear(soft_rst), .ctl_wr(ctl_wr_on),
    .mode_old(ctl_q[CTL_MODE_LSB +: NCH]), .sel_old(ctl_q[CTL_SEL_LSB +: SW]),
    .auto_old(ctl_q[CTL_AUTO]), .xch_old(ctl_q[CTL_XCH]),
    .mode_new(req_wdata[CTL_MODE_LSB +: NCH]), .sel_new(req_wdata[CTL_SEL_LSB +: SW]),
    .auto_new(req_wdata[CTL_AUTO]), .xch_new(req_wdata[CTL_XCH]),
    .tx_acc(tx_acc), .tx_nonempty(!txq_empty_o),
    .cs_n(cs_n_o), .start(seq_start_o));

  assign rsp_valid   = rvalid_q;
  assign rsp_rdata   = rdata_q;
  assign eng_clear_o = clr_q;
  assign ctl_o    = ctl_q;
  assign cfg_o    = cfg_q;
  assign int_en_o = int_q;
  assign dma_o    = dma_q;
  assign period_o = per_q;
  assign test_o   = tst_q;

  // R2: a response only follows a read request
  assert_rsp_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(rd));
  // R4: disabled receive read returns zero
  assert_rx_off_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && sel == SEL_RXD && !enabled) |=> (rsp_rdata == 32'h0));
  // R6: a disabled transmit write leaves an empty queue empty
  assert_drop_when_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && (sel == SEL_TXD || sel == SEL_MSG) && !enabled && txq_empty_o) |=> txq_empty_o);
  // R10: soft reset clears registers and the transmit queue
  assert_soft_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (ctl_o == '0) && (cfg_o == '0) && txq_empty_o && eng_clear_o);
  // R11: engine push into a full receive queue is dropped
  assert_rx_full_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && rxq_push_i && !rx_pop && !soft_rst) |=> rx_full);
endmodule

// File: tb/spi_regfront_tb.sv
module spi_regfront_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [11:0] req_addr;
  logic [31:0] req_wdata;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [31:0] ctl_o, cfg_o, int_en_o, dma_o, period_o, test_o, stat_i;
  logic [3:0]  cs_n_o;
  logic        seq_start_o, eng_clear_o;
  logic        txq_pop_i, txq_empty_o, rxq_push_i;
  logic [31:0] txq_data_o, rxq_data_i;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  localparam logic [11:0] A_RXD = 12'h000, A_TXD = 12'h004, A_CTL = 12'h008,
    A_CFG = 12'h00C, A_INT = 12'h010, A_DMA = 12'h014, A_STAT = 12'h018,
    A_PER = 12'h01C, A_TST = 12'h020, A_MSG = 12'h040;

  always #2 clk = ~clk;  // 250 MHz

  spi_regfront dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .ctl_o(ctl_o), .cfg_o(cfg_o), .int_en_o(int_en_o),
    .dma_o(dma_o), .period_o(period_o), .test_o(test_o), .stat_i(stat_i),
    .cs_n_o(cs_n_o), .seq_start_o(seq_start_o), .eng_clear_o(eng_clear_o),
    .txq_pop_i(txq_pop_i), .txq_data_o(txq_data_o), .txq_empty_o(txq_empty_o),
    .rxq_push_i(rxq_push_i), .rxq_data_i(rxq_data_i));

  function automatic logic [31:0] ctl(input bit en, input bit xch, input bit auto_go,
                                      input logic [3:0] mode, input logic [1:0] ch);
    return {12'h0, ch, 10'h0, mode, auto_go, xch, 1'b0, en};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    d = rsp_valid ? rsp_rdata : 32'hBAD0_BAD0;
    req_valid = 1'b0;
  endtask

  task automatic eng_push(input logic [31:0] d);
    @(negedge clk);
    rxq_push_i = 1'b1; rxq_data_i = d;
    @(negedge clk);
    rxq_push_i = 1'b0;
  endtask

  task automatic eng_pop(output logic [31:0] d);
    @(negedge clk);
    d = txq_data_o; txq_pop_i = 1'b1;
    @(negedge clk);
    txq_pop_i = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R1 cs_n", {28'h0, cs_n_o}, 32'hF);
    chk("R1 start", {31'h0, seq_start_o}, 0);
    chk("R1 txq empty", {31'h0, txq_empty_o}, 1);
    bus_rd(A_CTL, v); chk("R1 ctl", v, 0);
    bus_rd(A_PER, v); chk("R1 period", v, 0);
  endtask

  task automatic t_disabled;
    logic [31:0] v;
    bus_wr(A_TXD, 32'h1234);
    chk("R6 disabled drop", {31'h0, txq_empty_o}, 1);
    eng_push(32'h77);
    bus_rd(A_RXD, v); chk("R4 disabled read", v, 0);
    bus_wr(A_CTL, ctl(1, 0, 0, 4'h0, 0));   // enable; receive queue kept word
    bus_rd(A_RXD, v); chk("R4 first pop", v, 32'h77);
  endtask

  task automatic t_regs;
    logic [31:0] v;
    bus_rd(A_CTL, v); chk("R3 ctl readback", v, 32'h1);
    chk("R7 slave leaves cs", {28'h0, cs_n_o}, 32'hF);
    bus_wr(A_CFG, 32'hA5A5_0001); bus_wr(A_INT, 32'h0000_00FF);
    bus_wr(A_DMA, 32'h1357_9BDF); bus_wr(A_PER, 32'h0000_8001);
    bus_wr(A_TST, 32'hCAFE_F00D);
    bus_rd(A_CFG, v); chk("R3 cfg", v, 32'hA5A5_0001);
    bus_rd(A_INT, v); chk("R3 int_en", v, 32'h0000_00FF);
    bus_rd(A_DMA, v); chk("R3 dma", v, 32'h1357_9BDF);
    bus_rd(A_PER, v); chk("R3 period", v, 32'h0000_8001);
    bus_rd(A_TST, v); chk("R3 test", v, 32'hCAFE_F00D);
    stat_i = 32'h0000_0055;
    bus_wr(A_STAT, 32'hFFFF_FFFF);
    bus_rd(A_STAT, v); chk("R3 status from input", v, 32'h55);
    bus_rd(12'h024, v); chk("R2 hole read", v, 0);
    bus_rd(12'h044, v); chk("R2 beyond read", v, 0);
    bus_rd(12'h400, v); chk("R2 far read", v, 0);
    bus_wr(12'h00E, 32'h0BAD_0BAD);
    bus_rd(A_CFG, v); chk("R2 misaligned write ignored", v, 32'hA5A5_0001);
    bus_rd(12'h00D, v); chk("R2 misaligned read", v, 0);
    bus_wr(12'h030, 32'h1111_1111);
    bus_rd(12'h030, v); chk("R2 unmapped write ignored", v, 0);
  endtask

  task automatic t_rx;
    logic [31:0] v;
    bus_rd(A_RXD, v); chk("R4 empty read", v, 32'hDEAD_BEEF);
    eng_push(32'h11); eng_push(32'h22);
    bus_wr(A_RXD, 32'h99);
    bus_rd(A_RXD, v); chk("R4 pop order 1", v, 32'h11);
    bus_rd(A_RXD, v); chk("R4 pop order 2", v, 32'h22);
    bus_rd(A_RXD, v); chk("R5 rx write ignored", v, 32'hDEAD_BEEF);
    bus_rd(A_TXD, v); chk("R5 txd read", v, 0);
    bus_rd(A_MSG, v); chk("R5 msg read", v, 0);
    for (int i = 0; i < 65; i++) eng_push(32'(i));
    bus_rd(A_RXD, v); chk("R11 rx full first", v, 0);
    for (int i = 1; i < 63; i++) bus_rd(A_RXD, v);
    bus_rd(A_RXD, v); chk("R11 rx full last kept", v, 63);
    bus_rd(A_RXD, v); chk("R11 rx overflow dropped", v, 32'hDEAD_BEEF);
  endtask

  task automatic t_tx;
    logic [31:0] v;
    bus_wr(A_TXD, 32'hAAAA_0001);
    chk("R8 slave no start", {31'h0, seq_start_o}, 0);
    bus_wr(A_MSG, 32'hBBBB_0002);
    eng_pop(v); chk("R11 tx head 1", v, 32'hAAAA_0001);
    eng_pop(v); chk("R6 msg pushed", v, 32'hBBBB_0002);
    chk("R6 drained", {31'h0, txq_empty_o}, 1);
    for (int i = 0; i < 65; i++) bus_wr(A_TXD, 32'h100 + 32'(i));
    for (int i = 0; i < 63; i++) eng_pop(v);
    eng_pop(v); chk("R6 64th kept", v, 32'h13F);
    chk("R6 65th dropped", {31'h0, txq_empty_o}, 1);
  endtask

  task automatic t_master;
    logic [31:0] v;
    bus_wr(A_CTL, ctl(1, 0, 1, 4'b0100, 2));
    chk("R9 auto rise empty no start", {31'h0, seq_start_o}, 0);
    chk("R7 cs ch2", {28'h0, cs_n_o}, 32'hB);
    bus_wr(A_TXD, 32'h5);
    chk("R8 auto start", {31'h0, seq_start_o}, 1);
    @(negedge clk); chk("R8 one cycle", {31'h0, seq_start_o}, 0);
    eng_pop(v);
    bus_wr(A_CTL, ctl(1, 0, 0, 4'b0100, 2));
    bus_wr(A_TXD, 32'h6);
    chk("R8 auto off no start", {31'h0, seq_start_o}, 0);
    bus_wr(A_CTL, ctl(1, 0, 1, 4'b0100, 2));
    chk("R9 auto rise nonempty start", {31'h0, seq_start_o}, 1);
    bus_wr(A_CTL, ctl(1, 0, 1, 4'b0100, 2));
    chk("R9 auto steady no start", {31'h0, seq_start_o}, 0);
    eng_pop(v);
    bus_wr(A_CTL, ctl(1, 1, 1, 4'b0100, 2));
    chk("R9 xch with auto no start", {31'h0, seq_start_o}, 0);
    bus_wr(A_CTL, ctl(1, 0, 0, 4'b0100, 2));
    bus_wr(A_CTL, ctl(1, 1, 0, 4'b0100, 2));
    chk("R9 xch rise start", {31'h0, seq_start_o}, 1);
    bus_wr(A_CTL, ctl(1, 1, 0, 4'b0100, 2));
    chk("R9 xch steady no start", {31'h0, seq_start_o}, 0);
    bus_wr(A_CTL, ctl(1, 0, 0, 4'b0010, 1));
    chk("R7 cs ch1", {28'h0, cs_n_o}, 32'hD);
    bus_wr(A_CTL, ctl(1, 1, 0, 4'b0001, 3));
    chk("R9 non-master xch no start", {31'h0, seq_start_o}, 0);
    chk("R7 non-master keeps cs", {28'h0, cs_n_o}, 32'hD);
  endtask

  task automatic t_soft_reset;
    logic [31:0] v;
    bus_wr(A_CTL, ctl(1, 0, 0, 4'b0001, 0));
    bus_wr(A_CFG, 32'h1234_5678);
    bus_wr(A_TXD, 32'h42);
    eng_push(32'h43);
    bus_wr(A_CTL, 32'h0000_0008);
    chk("R10 clear pulse", {31'h0, eng_clear_o}, 1);
    chk("R10 cs high", {28'h0, cs_n_o}, 32'hF);
    chk("R10 txq flushed", {31'h0, txq_empty_o}, 1);
    bus_rd(A_CTL, v); chk("R10 ctl zero", v, 0);
    bus_rd(A_CFG, v); chk("R10 cfg zero", v, 0);
    bus_wr(A_CTL, 32'h1);
    bus_rd(A_RXD, v); chk("R10 rxq flushed", v, 32'hDEAD_BEEF);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
    req_wdata = '0; stat_i = '0; txq_pop_i = 1'b0; rxq_push_i = 1'b0;
    rxq_data_i = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_disabled;
    t_regs;
    t_rx;
    t_tx;
    t_master;
    t_soft_reset;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule